// File: doc/BRIEF.md
# Double-Pumped Two-Read One-Write Register File

This block is a processor register file. It serves two operand reads and one result write in every base cycle, yet each storage bank has only one address port. The block runs on a clock at twice the base rate. A `phase` input, which toggles on every 2X edge, marks the two halves of each base cycle.

In the first half (`phase` = 1), each bank's address comes from that bank's read address. The flow-through read data is captured into the output register at the 2X edge that closes this half. In the second half (`phase` = 0), every bank is addressed by the write address. The write, gated by `phase`, lands at the edge that closes the base cycle. Operands are therefore ready at mid-cycle. A read and a write of the same register in one base cycle return the value held before the write.

There is one bank per read port, so two in all. Every write goes to both banks, which keeps their contents equal. Everything runs in the single 2X clock domain. An asynchronous reset clears only the two output registers.

Top module: `dprf_top`

## Requirements
- R1: There are 16 registers of 16 bits, selected by a 4-bit address. Every register, register 0 included, stores and returns whatever value was written to it.
- R2: While `arst` is high, `rd_data_a` and `rd_data_b` are 0, and they become 0 at once, without waiting for a clock edge. Register contents are not cleared by reset.
- R3: The outputs load only at the 2X edge where `phase` is 1, taking the contents of the addressed registers. At an edge where `phase` is 0 the outputs keep their value.
- R4: A write takes effect only at a 2X edge where `phase` is 0 and `wr_en` is 1. With `wr_en` at 0 the contents do not change.
- R5: When a register is read and written in the same base cycle, the read returns the value held before the write. The new value is returned from the next base cycle onward.
- R6: The two read ports are independent. They may address different registers or the same register, and both outputs load at the same edge.
- R7: The caller toggles `phase` on every 2X edge and holds the read addresses and write inputs stable for both halves of a base cycle.
- R8: A `wr_en` pulse that is high only during the `phase` = 1 half writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the base rate |
| arst | input | 1 | Asynchronous reset, active high, clears the outputs |
| phase | input | 1 | 1 in the first half of a base cycle, 0 in the second half |
| rd_addr_a | input | 4 | Register address for read port A |
| rd_addr_b | input | 4 | Register address for read port B |
| wr_addr | input | 4 | Register address for the write |
| wr_data | input | 16 | Data to write |
| wr_en | input | 1 | Write request, acted on in the second half only |
| rd_data_a | output | 16 | Registered read data for port A |
| rd_data_b | output | 16 | Registered read data for port B |

## Verification
The main function is driven by seeded random base cycles in which read and write addresses often collide. A wrong sub-cycle ordering shows up as reads that return the value just written.

Directed cycles cover the following:
- Register 0 is checked as an ordinary register.
- Both ports read one address in the same cycle, which exposes a swapped or shared bank.
- A write pulse confined to the first half separates correct phase gating from a gate on `wr_en` alone.
- The outputs are sampled after both half-cycle edges, which separates capture on the phase enable from capture on every 2X edge.
- A reset raised between edges shows whether the clear is truly asynchronous.

// File: rtl/dprf_pkg.sv
package dprf_pkg;
  localparam int unsigned DPRF_REGS  = 16;
  localparam int unsigned DPRF_WIDTH = 16;
  localparam int unsigned DPRF_PORTS = 2;

  // Address a bank presents in a given half of the base cycle.
  function automatic logic [$clog2(DPRF_REGS)-1:0] bank_addr_sel(
    input logic                         first_half,
    input logic [$clog2(DPRF_REGS)-1:0] read_addr,
    input logic [$clog2(DPRF_REGS)-1:0] write_addr
  );
    return first_half ? read_addr : write_addr;
  endfunction

  // Array write strobe: only a pending write in the second half.
  function automatic logic write_gate(input logic first_half, input logic req);
    return req & ~first_half;
  endfunction

  // Output load strobe: the edge that closes the first half.
  function automatic logic capture_gate(input logic first_half);
    return first_half;
  endfunction
endpackage

// File: rtl/dprf_bank.sv
module dprf_bank #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Flow-through read on the single shared address.
  assign rdata = mem[addr];
endmodule

// File: rtl/dprf_capture.sv
module dprf_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst)      q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/dprf_top.sv
module dprf_top
  import dprf_pkg::*;
#(
  parameter int unsigned REGS  = DPRF_REGS,
  parameter int unsigned WIDTH = DPRF_WIDTH,
  localparam int unsigned AW   = $clog2(REGS),
  localparam int unsigned NP   = DPRF_PORTS
) (
  input  logic             clk2x,
  input  logic             arst,
  input  logic             phase,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b
);
  // Named internal events, observed by the bound checker.
  logic             wr_fire;
  logic             cap_fire;
  logic [AW-1:0]    rd_addr_v [NP];
  logic [WIDTH-1:0] out_v     [NP];

  assign wr_fire      = write_gate(phase, wr_en);
  assign cap_fire     = capture_gate(phase);
  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [AW-1:0]    bank_addr;
    logic [WIDTH-1:0] bank_q;

    assign bank_addr = bank_addr_sel(phase, rd_addr_v[p], wr_addr);

    dprf_bank #(.DEPTH(REGS), .DW(WIDTH)) u_bank (
      .clk   (clk2x),
      .we    (wr_fire),
      .addr  (bank_addr),
      .wdata (wr_data),
      .rdata (bank_q)
    );

    dprf_capture #(.DW(WIDTH)) u_cap (
      .clk  (clk2x),
      .arst (arst),
      .load (cap_fire),
      .d    (bank_q),
      .q    (out_v[p])
    );
  end

  assign rd_data_a = out_v[0];
  assign rd_data_b = out_v[1];
endmodule

// File: rtl/dprf_checker.sv
module dprf_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk2x,
  input logic             arst,
  input logic             phase,
  input logic             wr_fire,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [WIDTH-1:0] rd_data_b
);
  // Set after the first edge since reset, so $past is meaningful.
  logic armed;
  always_ff @(posedge clk2x or posedge arst) begin
    if (arst) armed <= 1'b0;
    else      armed <= 1'b1;
  end

  p_reset_zero_r2: assert property (@(posedge clk2x)
    arst |-> (rd_data_a == '0 && rd_data_b == '0));

  p_hold_a_r3: assert property (@(posedge clk2x) disable iff (arst)
    (armed && !$past(phase)) |-> $stable(rd_data_a));

  p_hold_b_r3: assert property (@(posedge clk2x) disable iff (arst)
    (armed && !$past(phase)) |-> $stable(rd_data_b));

  p_write_second_half_r4: assert property (@(posedge clk2x) disable iff (arst)
    wr_fire |-> !phase);

  p_phase_toggles_r7: assert property (@(posedge clk2x) disable iff (arst)
    armed |-> (phase != $past(phase)));
endmodule

bind dprf_top dprf_checker #(.WIDTH(WIDTH)) u_chk (
  .clk2x     (clk2x),
  .arst      (arst),
  .phase     (phase),
  .wr_fire   (wr_fire),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b)
);

// File: tb/sim_dprf_top.sv
module sim_dprf_top;
  localparam int PERIOD = 10;

  logic        clk2x = 1'b0;
  logic        arst  = 1'b1;
  logic        phase = 1'b0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [15:0] rd_data_a, rd_data_b;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [16];

  dprf_top u0 (
    .clk2x(clk2x), .arst(arst), .phase(phase),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  always #(PERIOD/2) clk2x = ~clk2x;

  // Value the bench expects a read to return: the table as it stood
  // at the start of the base cycle.
  function automatic logic [15:0] prior_value(input logic [3:0] a);
    return model[a];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One base cycle, entered and left just after a falling edge.
  task automatic base_cycle(input logic [3:0] ra, input logic [3:0] rb,
                            input logic [3:0] wa, input logic [15:0] wd,
                            input logic we, input string tag);
    logic [15:0] ea, eb;
    ea = prior_value(ra);
    eb = prior_value(rb);
    phase = 1'b1; rd_addr_a = ra; rd_addr_b = rb;
    wr_addr = wa; wr_data = wd; wr_en = we;
    @(negedge clk2x);
    check({tag, " port A mid-cycle"}, rd_data_a, ea);
    check({tag, " port B mid-cycle"}, rd_data_b, eb);
    phase = 1'b0;
    @(negedge clk2x);
    check({tag, " R3 port A held"}, rd_data_a, ea);
    check({tag, " R3 port B held"}, rd_data_b, eb);
    if (we) model[wa] = wd;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e_3d4c));
    @(negedge clk2x);
    check("R2 reset A", rd_data_a, 16'h0);
    check("R2 reset B", rd_data_b, 16'h0);
    @(negedge clk2x);
    arst = 1'b0;

    // R1: fill every register, register 0 included.
    for (int i = 0; i < 16; i++)
      base_cycle(4'(i), 4'(i), 4'(i), 16'(16'hA500 + i * 16'h0111), 1'b1, "R1 fill");
    for (int i = 0; i < 16; i++)
      base_cycle(4'(i), 4'(15 - i), 4'(0), 16'h0, 1'b0, "R1 readback");

    // R1: register 0 is not hardwired.
    base_cycle(4'd0, 4'd0, 4'd0, 16'hBEEF, 1'b1, "R1 reg0 write");
    base_cycle(4'd0, 4'd0, 4'd0, 16'h0, 1'b0, "R1 reg0 read");
    check("R1 reg0 value", rd_data_a, 16'hBEEF);

    // R5: read and write one register in the same base cycle.
    base_cycle(4'd7, 4'd7, 4'd7, 16'h1234, 1'b1, "R5 same-cycle old");
    base_cycle(4'd7, 4'd3, 4'd3, 16'h5678, 1'b1, "R5 next-cycle new");
    check("R5 new value visible", rd_data_a, 16'h1234);

    // R6: both ports on one address, then on different addresses.
    base_cycle(4'd9, 4'd9, 4'd0, 16'h0, 1'b0, "R6 shared address");
    base_cycle(4'd2, 4'd14, 4'd0, 16'h0, 1'b0, "R6 distinct addresses");

    // R4: wr_en low leaves contents unchanged.
    base_cycle(4'd5, 4'd5, 4'd5, 16'hDEAD, 1'b0, "R4 disabled write");
    base_cycle(4'd5, 4'd5, 4'd0, 16'h0, 1'b0, "R4 after disabled write");

    // R8: wr_en high only in the first half writes nothing.
    phase = 1'b1; rd_addr_a = 4'd6; rd_addr_b = 4'd6;
    wr_addr = 4'd6; wr_data = 16'hFACE; wr_en = 1'b1;
    @(negedge clk2x);
    phase = 1'b0; wr_en = 1'b0;
    @(negedge clk2x);
    base_cycle(4'd6, 4'd1, 4'd0, 16'h0, 1'b0, "R8 first-half pulse ignored");

    // Random traffic with frequent address collisions (R3, R4, R5, R6).
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ra, rb, wa;
      ra = 4'($urandom_range(0, 15));
      rb = ($urandom_range(0, 3) == 0) ? ra : 4'($urandom_range(0, 15));
      wa = ($urandom_range(0, 2) == 0) ? ra : 4'($urandom_range(0, 15));
      base_cycle(ra, rb, wa, 16'($urandom), 1'($urandom_range(0, 1)), "R5 random");
    end

    // R2: reset raised between edges clears outputs at once; contents kept.
    base_cycle(4'd4, 4'd8, 4'd0, 16'h0, 1'b0, "R2 pre-reset read");
    #2 arst = 1'b1;
    #1;
    check("R2 async clear A", rd_data_a, 16'h0);
    check("R2 async clear B", rd_data_b, 16'h0);
    @(negedge clk2x);
    @(negedge clk2x);
    arst = 1'b0;
    base_cycle(4'd4, 4'd8, 4'd0, 16'h0, 1'b0, "R2 contents kept");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule